// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block takes received Ethernet frames as a byte stream and stores each one in a region of packet memory. Each frame gets a slot made of one header word followed by its payload words. Software loads a start address and a budget counted in 32-bit words, then raises the receive enable. From then on the block fills the region frame after frame, with no wrap-around. It reports the address of the next free slot, so that software can walk the frames that have been completed.

The header slot is reserved when a frame starts, and the payload is packed little-endian into the words that follow it. The header is written only after the last payload word. The header carries a valid flag, an error flag, an out-of-band flag and an even-coded size field. A receive interrupt is raised after every completed frame and is cleared by writing one.

When the remaining budget can no longer hold a frame of the maximum size, the block sets its full flag. It then discards input until software loads a new region. Frames longer than the maximum are cut short and marked as errored. The input must stay idle for at least two cycles after the last byte of a frame.

Top module: `rx_frame_writer`

## Requirements
- R1: After reset the block makes no memory write, `irq_rx` and `st_full` are 0, and `st_wr_addr` is 0.
- R2: A frame whose first byte arrives while `rx_en` is 0 or `st_full` is 1 is discarded completely. It causes no memory write, no pointer change and no interrupt.
- R3: Payload byte k of a frame goes to bits [8·(k mod 4)+7 : 8·(k mod 4)] of the word at slot address + 4 + 4·floor(k/4). Payload words are written in ascending address order, and the unused lanes of the last word are written as 0.
- R4: The header word is written to the slot address after every payload word of that frame has been written.
- R5: The header holds 1 in bit 31, the error flag in bit 30, the out-of-band flag in bit 29 and the size field in bits [15:0]. All other bits are 0. For an even byte count n the size field is n. For an odd n it is n+1 with bit 0 set.
- R6: `in_error` or `in_oob` asserted on any accepted byte of a frame sets the matching header flag. An errored frame is still stored and still consumes space.
- R7: After each stored frame, `st_wr_addr` advances by 4 + 4·ceil(n/4), where n is the stored byte count. The change becomes visible only after the header write has been presented.
- R8: The budget falls by 1 + ceil(n/4) words per stored frame. When the block is enabled, between frames, and the budget is below MAX_BYTES/4 + 1, `st_full` is set. It stays set until the next load.
- R9: A `ctl_load` pulse sets the pointer to `ctl_base` with bits [1:0] cleared, sets the budget to `ctl_budget`, and clears `st_full`.
- R10: `irq_rx` rises after every stored frame and stays high until `irq_clr` is 1. A new frame that completes in the same cycle as the clear wins.
- R11: Bytes beyond MAX_BYTES are discarded. The size then equals MAX_BYTES and the header error flag is set.
- R12: `st_ready` equals `rx_en` and not `st_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| ctl_load | input | 1 | Pulse: load start address and budget |
| ctl_base | input | ADDR_W | Region start address (bytes) |
| ctl_budget | input | BUDGET_W | Region size in 32-bit words |
| irq_clr | input | 1 | Write-one-to-clear for the receive interrupt |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Last byte of the frame |
| in_error | input | 1 | Frame error marker |
| in_oob | input | 1 | Out-of-band data marker |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| st_wr_addr | output | ADDR_W | Address of the next free slot |
| st_full | output | 1 | Region exhausted |
| st_ready | output | 1 | Ready to accept frames |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with MAX_BYTES = 32, so a full-size slot takes 9 words. A 30-word region is then used up after five short frames, and the move to the full state and the drops that follow can be reached in a short run. A 40-byte frame crosses the truncation limit. A 9-word region reloaded afterwards fills with a single 1-byte frame, which also covers the odd-size coding at its smallest.

// File: rtl/rxw_pkg.sv
// Package: shared types and the header encoder for the receive frame writer.
// Assumes byte counts fit into 16 bits.
package rxw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_DROP,
        S_HDR,
        S_COMMIT
    } rxw_state_e;

    localparam int HDR_VALID_BIT = 31;
    localparam int HDR_ERR_BIT   = 30;
    localparam int HDR_OOB_BIT   = 29;

    // Builds a header word: flags on top, even-coded size at the bottom.
    function automatic logic [31:0] rxw_make_hdr(input logic err,
                                                 input logic oob,
                                                 input logic [15:0] nbytes);
        logic [15:0] sz;
        logic [31:0] h;
        sz = nbytes[0] ? ((nbytes + 16'd1) | 16'd1) : nbytes;
        h = 32'd0;
        h[HDR_VALID_BIT] = 1'b1;
        h[HDR_ERR_BIT]   = err;
        h[HDR_OOB_BIT]   = oob;
        h[15:0]          = sz;
        return h;
    endfunction

endpackage

// File: rtl/rxw_packer.sv
// Module: packs accepted bytes little-endian into 32-bit words and emits one
// registered write per completed or final word. It counts the stored bytes
// and flags truncation beyond MAX_BYTES.
// Assumes MAX_BYTES is a multiple of 4, so that nothing is pending at the limit.
module rxw_packer #(
    parameter int ADDR_W    = 16,
    parameter int MAX_BYTES = 1536,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              take,
    input  logic [7:0]        data,
    input  logic              last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic [CNT_W-1:0]  cnt,
    output logic              trunc
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);

    logic [31:0]       word_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              trunc_q;

    logic [31:0]       word_b;
    logic [ADDR_W-1:0] addr_b;
    logic [CNT_W-1:0]  cnt_b;
    logic [1:0]        lane;
    logic [31:0]       word_n;

    // Selects the frame-start values or the running values.
    always_comb begin
        word_b = start ? 32'd0 : word_q;
        addr_b = start ? start_addr : addr_q;
        cnt_b  = start ? '0 : cnt_q;
        lane   = cnt_b[1:0];
        word_n = word_b | ({24'd0, data} << {lane, 3'b000});
    end

    // Accumulates bytes, flushes full or final words, and tracks truncation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start) begin
                word_q  <= '0;
                addr_q  <= start_addr;
                cnt_q   <= '0;
                trunc_q <= 1'b0;
            end
            if (take) begin
                if (cnt_b < CNT_MAX) begin
                    cnt_q <= cnt_b + 1'b1;
                    if (lane == 2'd3 || last) begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr_b;
                        wr_data <= word_n;
                        addr_q  <= addr_b + ADDR_W'(4);
                        word_q  <= '0;
                    end else begin
                        word_q <= word_n;
                    end
                end else begin
                    trunc_q <= 1'b1;
                end
            end
        end
    end

    assign cnt   = cnt_q;
    assign trunc = trunc_q;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);  // R11

endmodule

// File: rtl/rxw_space.sv
// Module: keeps the free-slot pointer, the remaining word budget, the full
// flag and the receive interrupt latch.
// Assumes that no load arrives while a frame is being stored.
module rxw_space #(
    parameter int ADDR_W    = 16,
    parameter int BUDGET_W  = 16,
    parameter int MAX_WORDS = 385
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_base,
    input  logic [BUDGET_W-1:0] load_budget,
    input  logic                idle_en,
    input  logic                advance,
    input  logic [BUDGET_W-1:0] words,
    input  logic                irq_clr,
    output logic [ADDR_W-1:0]   ptr,
    output logic [BUDGET_W-1:0] budget,
    output logic                full,
    output logic                irq
);
    localparam logic [BUDGET_W-1:0] WORDS_MAX = BUDGET_W'(MAX_WORDS);

    logic [ADDR_W-1:0]   ptr_q;
    logic [BUDGET_W-1:0] bud_q;
    logic                full_q;
    logic                irq_q;

    // Updates pointer and budget on load or frame commit, and sets full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            bud_q  <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            ptr_q  <= {load_base[ADDR_W-1:2], 2'b00};
            bud_q  <= load_budget;
            full_q <= 1'b0;
        end else begin
            if (advance) begin
                ptr_q <= ptr_q + ADDR_W'({words, 2'b00});
                bud_q <= bud_q - words;
            end
            if (idle_en && bud_q < WORDS_MAX)
                full_q <= 1'b1;
        end
    end

    // Latches the receive interrupt; a commit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= (irq_q & ~irq_clr) | advance;
    end

    assign ptr    = ptr_q;
    assign budget = bud_q;
    assign full   = full_q;
    assign irq    = irq_q;

    AST_BUDGET_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |-> (bud_q >= words));  // R8
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !load) |=> full_q);  // R8
    AST_IRQ_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(advance));  // R10

endmodule

// File: rtl/rx_frame_writer.sv
// Module: top level of the receive frame writer. Sequences each frame:
// reserve the header slot, pack the payload after it, write the header, and
// then commit pointer, budget and interrupt.
// Assumes in_valid stays low for at least two cycles after in_last.
module rx_frame_writer
    import rxw_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUDGET_W  = 16,
    parameter int MAX_BYTES = 1536
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                ctl_load,
    input  logic [ADDR_W-1:0]   ctl_base,
    input  logic [BUDGET_W-1:0] ctl_budget,
    input  logic                irq_clr,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    input  logic                in_error,
    input  logic                in_oob,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [31:0]         mem_wdata,
    output logic [ADDR_W-1:0]   st_wr_addr,
    output logic                st_full,
    output logic                st_ready,
    output logic                irq_rx
);
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int MAX_WORDS = MAX_BYTES / 4 + 1;
    localparam logic [BUDGET_W-1:0] WORDS_MAX = BUDGET_W'(MAX_WORDS);

    rxw_state_e state_q, state_n;

    logic                err_q, oob_q;
    logic                hd_we;
    logic [ADDR_W-1:0]   hd_addr;
    logic [31:0]         hd_data;

    logic [ADDR_W-1:0]   ptr;
    logic [BUDGET_W-1:0] budget;
    logic                full;

    logic                accept, pk_start, pk_take;
    logic                pk_we, pk_trunc;
    logic [ADDR_W-1:0]   pk_addr;
    logic [31:0]         pk_data;
    logic [CNT_W-1:0]    pk_cnt;
    logic [BUDGET_W-1:0] slot_words;

    // Decides acceptance at frame start and the next sequencing state.
    always_comb begin
        accept   = rx_en && !full && (budget >= WORDS_MAX);
        pk_start = (state_q == S_IDLE) && in_valid && accept;
        pk_take  = pk_start || ((state_q == S_RECV) && in_valid);
        state_n  = state_q;
        case (state_q)
            S_IDLE:
                if (in_valid) begin
                    if (accept)
                        state_n = in_last ? S_HDR : S_RECV;
                    else if (!in_last)
                        state_n = S_DROP;
                end
            S_RECV:   if (in_valid && in_last) state_n = S_HDR;
            S_DROP:   if (in_valid && in_last) state_n = S_IDLE;
            S_HDR:    state_n = S_COMMIT;
            S_COMMIT: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // Slot size in words: header plus the rounded-up payload.
    always_comb begin
        slot_words = BUDGET_W'(1) + BUDGET_W'((pk_cnt + CNT_W'(3)) >> 2);
    end

    // Advances the state and gathers the per-frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= 1'b0;
            oob_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (pk_start) begin
                err_q <= in_error;
                oob_q <= in_oob;
            end else if (pk_take) begin
                err_q <= err_q | in_error;
                oob_q <= oob_q | in_oob;
            end
        end
    end

    // Presents the header write one cycle after the last payload byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_we   <= 1'b0;
            hd_addr <= '0;
            hd_data <= '0;
        end else begin
            hd_we <= (state_q == S_HDR);
            if (state_q == S_HDR) begin
                hd_addr <= ptr;
                hd_data <= rxw_make_hdr(err_q | pk_trunc, oob_q, 16'(pk_cnt));
            end
        end
    end

    rxw_packer #(
        .ADDR_W    (ADDR_W),
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W)
    ) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (pk_start),
        .start_addr (ptr + ADDR_W'(4)),
        .take       (pk_take),
        .data       (in_data),
        .last       (in_last),
        .wr_en      (pk_we),
        .wr_addr    (pk_addr),
        .wr_data    (pk_data),
        .cnt        (pk_cnt),
        .trunc      (pk_trunc)
    );

    rxw_space #(
        .ADDR_W    (ADDR_W),
        .BUDGET_W  (BUDGET_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_space (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ctl_load),
        .load_base   (ctl_base),
        .load_budget (ctl_budget),
        .idle_en     ((state_q == S_IDLE) && rx_en),
        .advance     (state_q == S_COMMIT),
        .words       (slot_words),
        .irq_clr     (irq_clr),
        .ptr         (ptr),
        .budget      (budget),
        .full        (full),
        .irq         (irq_rx)
    );

    assign mem_we     = pk_we | hd_we;
    assign mem_addr   = hd_we ? hd_addr : pk_addr;
    assign mem_wdata  = hd_we ? hd_data : pk_data;
    assign st_wr_addr = ptr;
    assign st_full    = full;
    assign st_ready   = rx_en & ~full;

    AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HDR || state_q == S_COMMIT) |-> !in_valid);  // R4
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DROP) |-> !mem_we);  // R2
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(pk_we && hd_we));  // R4
    AST_PTR_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_load && $past(!ctl_load) && ptr != $past(ptr)) |-> $past(hd_we));  // R7

endmodule

// File: tb/rx_frame_writer_test.sv
module rx_frame_writer_test;
    localparam int ADDR_W = 16;
    localparam int BUDGET_W = 16;
    localparam int MAXB = 32;
    localparam int MAXW = MAXB / 4 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0;
    logic ctl_load = 1'b0;
    logic [ADDR_W-1:0] ctl_base = '0;
    logic [BUDGET_W-1:0] ctl_budget = '0;
    logic irq_clr = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic in_error = 1'b0;
    logic in_oob = 1'b0;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [ADDR_W-1:0] st_wr_addr;
    logic st_full, st_ready, irq_rx;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] exp_addr[$];
    logic [31:0] exp_data[$];

    int m_ptr = 0;
    int m_budget = 0;
    bit m_full = 0;

    always #5 clk = ~clk;

    rx_frame_writer #(
        .ADDR_W(ADDR_W), .BUDGET_W(BUDGET_W), .MAX_BYTES(MAXB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ctl_load(ctl_load),
        .ctl_base(ctl_base), .ctl_budget(ctl_budget), .irq_clr(irq_clr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_error(in_error), .in_oob(in_oob), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st_wr_addr(st_wr_addr),
        .st_full(st_full), .st_ready(st_ready), .irq_rx(irq_rx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every memory write must match the next scoreboard entry (R3 R4 R5).
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_addr.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2: unexpected write addr %h data %h expected none", mem_addr, mem_wdata);
            end else begin
                chk("R3 R4 write address", {16'd0, mem_addr}, {16'd0, exp_addr.pop_front()});
                chk("R3 R5 R6 write data", mem_wdata, exp_data.pop_front());
            end
        end
    end

    // Driver: predicts the stored image, pushes it, then drives the bytes.
    task automatic send_frame(input int n, input int err_at, input int oob_at, input logic [7:0] seed);
        bit acc;
        int stored, nw;
        logic [31:0] w, h;
        logic [15:0] sz;
        acc = rx_en && !m_full && (m_budget >= MAXW);
        if (acc) begin
            stored = (n > MAXB) ? MAXB : n;
            nw = (stored + 3) / 4;
            for (int k = 0; k < nw; k++) begin
                w = 32'd0;
                for (int b = 0; b < 4; b++)
                    if (4 * k + b < stored)
                        w[8*b +: 8] = seed + 8'(4 * k + b);
                exp_addr.push_back(16'(m_ptr + 4 + 4 * k));
                exp_data.push_back(w);
            end
            sz = (stored % 2 == 1) ? 16'(stored + 1) | 16'd1 : 16'(stored);
            h = 32'h8000_0000 | {16'd0, sz};
            if (err_at >= 0 || n > MAXB) h[30] = 1'b1;
            if (oob_at >= 0) h[29] = 1'b1;
            exp_addr.push_back(16'(m_ptr));
            exp_data.push_back(h);
            m_ptr = m_ptr + 4 + 4 * nw;
            m_budget = m_budget - 1 - nw;
            if (m_budget < MAXW) m_full = 1;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data = seed + 8'(i);
            in_last = (i == n - 1);
            in_error = (i == err_at);
            in_oob = (i == oob_at);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        in_error = 1'b0;
        in_oob = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic load_region(input int base, input int budget);
        @(negedge clk);
        ctl_load = 1'b1;
        ctl_base = 16'(base);
        ctl_budget = 16'(budget);
        @(negedge clk);
        ctl_load = 1'b0;
        m_ptr = base & ~3;
        m_budget = budget;
        m_full = 0;
        repeat (2) @(negedge clk);
        if (rx_en && m_budget < MAXW) m_full = 1;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'd0, irq_rx}, 32'd0);
        chk("R1 full", {31'd0, st_full}, 32'd0);
        chk("R1 pointer", {16'd0, st_wr_addr}, 32'd0);
        chk("R1 write strobe", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: disabled receiver drops the frame
        send_frame(6, -1, -1, 8'h10);
        chk("R2 pointer unchanged", {16'd0, st_wr_addr}, 32'd0);
        chk("R2 no irq", {31'd0, irq_rx}, 32'd0);
        chk("R12 ready low when disabled", {31'd0, st_ready}, 32'd0);

        // R9: load aligns base, clears full
        rx_en = 1'b1;
        load_region(16'h103, 30);
        chk("R9 aligned base", {16'd0, st_wr_addr}, 32'h100);
        chk("R12 ready", {31'd0, st_ready}, 32'd1);
        chk("R8 not full", {31'd0, st_full}, 32'd0);

        // R3 R7 R10: even-length frame
        send_frame(8, -1, -1, 8'hA0);
        chk("R7 pointer after 8 bytes", {16'd0, st_wr_addr}, 32'(m_ptr));
        chk("R10 irq raised", {31'd0, irq_rx}, 32'd1);
        clear_irq();
        chk("R10 irq cleared", {31'd0, irq_rx}, 32'd0);

        // R5 R6: odd length with error on last byte
        send_frame(5, 4, -1, 8'h31);
        chk("R6 errored frame consumes space", {16'd0, st_wr_addr}, 32'(m_ptr));
        chk("R10 irq again", {31'd0, irq_rx}, 32'd1);

        // R11: oversized frame truncated
        send_frame(40, -1, -1, 8'h50);
        chk("R11 pointer after truncation", {16'd0, st_wr_addr}, 32'(m_ptr));

        // R6: out-of-band flag on first byte, odd size 3
        send_frame(3, -1, 0, 8'hC7);
        chk("R7 pointer after 3 bytes", {16'd0, st_wr_addr}, 32'(m_ptr));
        chk("R8 still room", {31'd0, st_full}, 32'd0);

        // R8: this frame drains the budget below one full slot
        send_frame(16, -1, -1, 8'h02);
        chk("R8 full set", {31'd0, st_full}, {31'd0, m_full});
        chk("R12 ready drops", {31'd0, st_ready}, 32'd0);

        // R2: full drops input
        send_frame(4, -1, -1, 8'h77);
        chk("R2 pointer held while full", {16'd0, st_wr_addr}, 32'(m_ptr));
        chk("R8 full sticky", {31'd0, st_full}, 32'd1);

        // R9 R5: reload region, single odd byte
        load_region(16'h200, 9);
        chk("R9 full cleared", {31'd0, st_full}, 32'd0);
        send_frame(1, -1, -1, 8'hEE);
        chk("R7 pointer after 1 byte", {16'd0, st_wr_addr}, 32'h208);
        chk("R8 full again", {31'd0, st_full}, 32'd1);

        repeat (4) @(negedge clk);
        chk("R4 all expected writes seen", 32'(exp_addr.size()), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule